// File: doc/BRIEF.md
# Access Permission and Fault Encoder

This block is the final stage of a long-format translation walk. It takes the attribute bits of the terminal (block or page) descriptor together with the override bits gathered from every table descriptor on the way down. It folds the overrides into one merged attribute word and judges a single access against it. The access is a read, write or execute request at user or privileged level.

It is purely combinational. A walker drives the walk level it stopped at and can flag an upstream translation fault. The block returns the merged attributes, the read, write and execute rights for a TLB fill, a fault flag and a long-format fault status word. Bit positions are parameters, checked at elaboration time.

Top module: `apa_access_check`

## Requirements
- R1: The merged attribute word equals the leaf attributes with table override bit 0 OR'd into bit 11 (privileged execute-never), table bit 1 OR'd into bit 12 (execute-never) and table bit 3 OR'd into bit 5 (write-forbid). All other leaf bits pass unchanged, except as R2 states.
- R2: Table override bit 2 has inverted sense: when it is set, merged bit 4 (user access enable) is cleared. Table bit 4 has no effect on any output.
- R3: When `xlat_flt_i` is high, the block raises a fault with status `0x200 | (1<<2) | level`, whatever the attributes and access are.
- R4: Otherwise, if merged bit 8 (access flag) is zero, the block raises an access fault with status `0x200 | (2<<2) | level`. This takes precedence over every permission check.
- R5: Otherwise, a user access (`acc_user_i`=1) with merged bit 4 zero raises a permission fault with status `0x200 | (3<<2) | level`.
- R6: Execute permission is withheld when merged bit 12 is set, or when the access is privileged and merged bit 11 is set. An execute access (code 2) that is then not allowed raises a permission fault (status type 3).
- R7: Write permission is withheld when merged bit 5 is set. A write access (code 1) then raises a permission fault (status type 3).
- R8: With no fault, `fault_o` is 0, `fsr_o` is 0 and `perm_r_o` is 1. Access codes 0 and 3 both act as reads and never fault on permissions.
- R9: Whenever `fault_o` is 1, all three permission outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_kind_i | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 treated as read |
| acc_user_i | input | 1 | 1 for an unprivileged access |
| leaf_attr_i | input | ATTR_W (13) | Attribute field of the terminal descriptor |
| tbl_attr_i | input | TBL_W (5) | Table override bits accumulated over the walk |
| walk_level_i | input | LEVEL_W (2) | Level at which the walk ended |
| xlat_flt_i | input | 1 | Upstream translation fault |
| merged_attr_o | output | ATTR_W (13) | Attributes after the overrides are applied |
| perm_r_o | output | 1 | Read right for caching |
| perm_w_o | output | 1 | Write right for caching |
| perm_x_o | output | 1 | Execute right for caching |
| fault_o | output | 1 | Access faults |
| fsr_o | output | FSR_W (10) | Long-format fault status, zero when no fault |

## Verification
The block holds no state, so a wrong internal value shows at the ports in the same evaluation as the input that exposes it. There is no latency to wait out. A fault-priority error surfaces as a status word of the wrong type, and a mis-wired override surfaces as a wrong merged bit. A sweep over every access code, privilege, relevant leaf bit, override pattern, level and upstream-fault value therefore reaches each such error with a single vector.

// File: rtl/apa_pkg.sv
package apa_pkg;

   typedef enum logic [1:0] {
      ACC_RD  = 2'd0,
      ACC_WR  = 2'd1,
      ACC_EX  = 2'd2,
      ACC_RSV = 2'd3
   } acc_kind_e;

   typedef enum logic [3:0] {
      FT_NONE   = 4'd0,
      FT_XLAT   = 4'd1,
      FT_ACCESS = 4'd2,
      FT_PERM   = 4'd3
   } flt_type_e;

   typedef struct packed {
      logic xn;
      logic pxn;
      logic af;
      logic wr_off;
      logic user_ok;
   } leaf_fields_t;

endpackage

// File: rtl/apa_attr_merge.sv
module apa_attr_merge
   import apa_pkg::*;
#(
   parameter int ATTR_W      = 13,
   parameter int TBL_W       = 5,
   parameter int USER_BIT    = 4,
   parameter int WROFF_BIT   = 5,
   parameter int AF_BIT      = 8,
   parameter int PXN_BIT     = 11,
   parameter int XN_BIT      = 12,
   parameter int TBL_PXN     = 0,
   parameter int TBL_XN      = 1,
   parameter int TBL_PRIV    = 2,
   parameter int TBL_WROFF   = 3
) (
   input  logic [ATTR_W-1:0] leaf_i,
   input  logic [TBL_W-1:0]  tbl_i,
   output logic [ATTR_W-1:0] merged_o,
   output leaf_fields_t      fields_o
);

   generate
      if (XN_BIT >= ATTR_W || PXN_BIT >= ATTR_W || AF_BIT >= ATTR_W ||
          WROFF_BIT >= ATTR_W || USER_BIT >= ATTR_W) begin : g_bad_attr
         $error("apa_attr_merge: attribute bit position outside ATTR_W");
      end
      if (TBL_PXN >= TBL_W || TBL_XN >= TBL_W || TBL_PRIV >= TBL_W ||
          TBL_WROFF >= TBL_W) begin : g_bad_tbl
         $error("apa_attr_merge: override bit position outside TBL_W");
      end
   endgenerate

   for (genvar b = 0; b < ATTR_W; b++) begin : g_bit
      if (b == PXN_BIT) begin : g_pxn
         assign merged_o[b] = leaf_i[b] | tbl_i[TBL_PXN];
      end else if (b == XN_BIT) begin : g_xn
         assign merged_o[b] = leaf_i[b] | tbl_i[TBL_XN];
      end else if (b == WROFF_BIT) begin : g_wr
         assign merged_o[b] = leaf_i[b] | tbl_i[TBL_WROFF];
      end else if (b == USER_BIT) begin : g_user
         assign merged_o[b] = leaf_i[b] & ~tbl_i[TBL_PRIV];
      end else begin : g_pass
         assign merged_o[b] = leaf_i[b];
      end
   end

   assign fields_o.xn      = merged_o[XN_BIT];
   assign fields_o.pxn     = merged_o[PXN_BIT];
   assign fields_o.af      = merged_o[AF_BIT];
   assign fields_o.wr_off  = merged_o[WROFF_BIT];
   assign fields_o.user_ok = merged_o[USER_BIT];

endmodule

// File: rtl/apa_perm_eval.sv
module apa_perm_eval
   import apa_pkg::*;
(
   input  leaf_fields_t fields_i,
   input  logic [1:0]   acc_kind_i,
   input  logic         acc_user_i,
   input  logic         xlat_flt_i,
   output logic         perm_r_o,
   output logic         perm_w_o,
   output logic         perm_x_o,
   output flt_type_e    ftype_o
);

   logic exec_ok;
   logic write_ok;
   acc_kind_e kind;

   assign kind     = acc_kind_e'(acc_kind_i);
   assign exec_ok  = ~(fields_i.xn | (~acc_user_i & fields_i.pxn));
   assign write_ok = ~fields_i.wr_off;

   always_comb begin
      if (xlat_flt_i) begin
         ftype_o = FT_XLAT;
      end else if (!fields_i.af) begin
         ftype_o = FT_ACCESS;
      end else if (acc_user_i && !fields_i.user_ok) begin
         ftype_o = FT_PERM;
      end else if (kind == ACC_EX && !exec_ok) begin
         ftype_o = FT_PERM;
      end else if (kind == ACC_WR && !write_ok) begin
         ftype_o = FT_PERM;
      end else begin
         ftype_o = FT_NONE;
      end
   end

   assign perm_r_o = (ftype_o == FT_NONE);
   assign perm_w_o = (ftype_o == FT_NONE) & write_ok;
   assign perm_x_o = (ftype_o == FT_NONE) & exec_ok;

endmodule

// File: rtl/apa_fsr_pack.sv
module apa_fsr_pack
   import apa_pkg::*;
#(
   parameter int LEVEL_W  = 2,
   parameter int TYPE_W   = 4,
   parameter int TYPE_LSB = 2,
   parameter int FMT_BIT  = 9,
   localparam int FSR_W   = FMT_BIT + 1
) (
   input  flt_type_e          ftype_i,
   input  logic [LEVEL_W-1:0] level_i,
   output logic               fault_o,
   output logic [FSR_W-1:0]   fsr_o
);

   generate
      if (TYPE_LSB < LEVEL_W) begin : g_overlap_lo
         $error("apa_fsr_pack: type field overlaps level field");
      end
      if (TYPE_LSB + TYPE_W > FMT_BIT) begin : g_overlap_hi
         $error("apa_fsr_pack: type field overlaps format bit");
      end
      if (TYPE_W < 2) begin : g_narrow
         $error("apa_fsr_pack: type field too narrow for the codes");
      end
   endgenerate

   assign fault_o = (ftype_i != FT_NONE);

   always_comb begin
      fsr_o = '0;
      if (fault_o) begin
         fsr_o[FMT_BIT]                = 1'b1;
         fsr_o[TYPE_LSB +: TYPE_W]     = TYPE_W'(ftype_i);
         fsr_o[LEVEL_W-1:0]            = level_i;
      end
   end

endmodule

// File: rtl/apa_access_check.sv
module apa_access_check
   import apa_pkg::*;
#(
   parameter int ATTR_W    = 13,
   parameter int TBL_W     = 5,
   parameter int LEVEL_W   = 2,
   parameter int TYPE_W    = 4,
   parameter int TYPE_LSB  = 2,
   parameter int FMT_BIT   = 9,
   parameter int USER_BIT  = 4,
   parameter int WROFF_BIT = 5,
   parameter int AF_BIT    = 8,
   parameter int PXN_BIT   = 11,
   parameter int XN_BIT    = 12,
   parameter int TBL_PXN   = 0,
   parameter int TBL_XN    = 1,
   parameter int TBL_PRIV  = 2,
   parameter int TBL_WROFF = 3,
   localparam int FSR_W    = FMT_BIT + 1
) (
   input  logic [1:0]         acc_kind_i,
   input  logic               acc_user_i,
   input  logic [ATTR_W-1:0]  leaf_attr_i,
   input  logic [TBL_W-1:0]   tbl_attr_i,
   input  logic [LEVEL_W-1:0] walk_level_i,
   input  logic               xlat_flt_i,
   output logic [ATTR_W-1:0]  merged_attr_o,
   output logic               perm_r_o,
   output logic               perm_w_o,
   output logic               perm_x_o,
   output logic               fault_o,
   output logic [FSR_W-1:0]   fsr_o
);

   leaf_fields_t fields;
   flt_type_e    ftype;

   apa_attr_merge #(
      .ATTR_W   (ATTR_W),
      .TBL_W    (TBL_W),
      .USER_BIT (USER_BIT),
      .WROFF_BIT(WROFF_BIT),
      .AF_BIT   (AF_BIT),
      .PXN_BIT  (PXN_BIT),
      .XN_BIT   (XN_BIT),
      .TBL_PXN  (TBL_PXN),
      .TBL_XN   (TBL_XN),
      .TBL_PRIV (TBL_PRIV),
      .TBL_WROFF(TBL_WROFF)
   ) u_merge (
      .leaf_i  (leaf_attr_i),
      .tbl_i   (tbl_attr_i),
      .merged_o(merged_attr_o),
      .fields_o(fields)
   );

   apa_perm_eval u_eval (
      .fields_i  (fields),
      .acc_kind_i(acc_kind_i),
      .acc_user_i(acc_user_i),
      .xlat_flt_i(xlat_flt_i),
      .perm_r_o  (perm_r_o),
      .perm_w_o  (perm_w_o),
      .perm_x_o  (perm_x_o),
      .ftype_o   (ftype)
   );

   apa_fsr_pack #(
      .LEVEL_W (LEVEL_W),
      .TYPE_W  (TYPE_W),
      .TYPE_LSB(TYPE_LSB),
      .FMT_BIT (FMT_BIT)
   ) u_pack (
      .ftype_i(ftype),
      .level_i(walk_level_i),
      .fault_o(fault_o),
      .fsr_o  (fsr_o)
   );

endmodule

// File: rtl/apa_access_check_chk.sv
module apa_access_check_chk #(
   parameter int ATTR_W    = 13,
   parameter int TBL_W     = 5,
   parameter int LEVEL_W   = 2,
   parameter int TYPE_W    = 4,
   parameter int TYPE_LSB  = 2,
   parameter int FMT_BIT   = 9,
   parameter int USER_BIT  = 4,
   parameter int AF_BIT    = 8,
   parameter int TBL_PRIV  = 2,
   localparam int FSR_W    = FMT_BIT + 1
) (
   input  logic [1:0]         acc_kind_i,
   input  logic               acc_user_i,
   input  logic [ATTR_W-1:0]  leaf_attr_i,
   input  logic [TBL_W-1:0]   tbl_attr_i,
   input  logic [LEVEL_W-1:0] walk_level_i,
   input  logic               xlat_flt_i,
   input  logic [ATTR_W-1:0]  merged_attr_o,
   input  logic               perm_r_o,
   input  logic               perm_w_o,
   input  logic               perm_x_o,
   input  logic               fault_o,
   input  logic [FSR_W-1:0]   fsr_o
);

   logic [TYPE_W-1:0] ftype_seen;
   assign ftype_seen = fsr_o[TYPE_LSB +: TYPE_W];

   always_comb begin
      // R9
      fault_no_perm_chk: assert (!fault_o || !(perm_r_o || perm_w_o || perm_x_o));
      // R8
      clean_status_chk: assert (fault_o || (fsr_o == '0 && perm_r_o));
      // R3
      xlat_passthru_chk: assert (!xlat_flt_i ||
         (fault_o && fsr_o[FMT_BIT] && ftype_seen == TYPE_W'(1) &&
          fsr_o[LEVEL_W-1:0] == walk_level_i));
      // R2
      force_priv_chk: assert (!tbl_attr_i[TBL_PRIV] || !merged_attr_o[USER_BIT]);
      // R4
      af_first_chk: assert (xlat_flt_i || merged_attr_o[AF_BIT] ||
         (fault_o && ftype_seen == TYPE_W'(2)));
      // R5
      user_gate_chk: assert (xlat_flt_i || !merged_attr_o[AF_BIT] || !acc_user_i ||
         merged_attr_o[USER_BIT] || ftype_seen == TYPE_W'(3));
      // R7
      write_grant_chk: assert (fault_o || acc_kind_i != 2'd1 || perm_w_o);
      // R6
      exec_grant_chk: assert (fault_o || acc_kind_i != 2'd2 || perm_x_o);
   end

endmodule

bind apa_access_check apa_access_check_chk #(
   .ATTR_W  (ATTR_W),
   .TBL_W   (TBL_W),
   .LEVEL_W (LEVEL_W),
   .TYPE_W  (TYPE_W),
   .TYPE_LSB(TYPE_LSB),
   .FMT_BIT (FMT_BIT),
   .USER_BIT(USER_BIT),
   .AF_BIT  (AF_BIT),
   .TBL_PRIV(TBL_PRIV)
) u_chk (.*);

// File: tb/sim_apa_access_check.sv
module sim_apa_access_check;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic [1:0]  acc_kind  = '0;
   logic        acc_user  = 1'b0;
   logic [12:0] leaf_attr = '0;
   logic [4:0]  tbl_attr  = '0;
   logic [1:0]  level     = '0;
   logic        xlat      = 1'b0;
   logic [12:0] merged;
   logic        pr, pw, px, flt;
   logic [9:0]  fsr;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   apa_access_check u0 (
      .acc_kind_i   (acc_kind),
      .acc_user_i   (acc_user),
      .leaf_attr_i  (leaf_attr),
      .tbl_attr_i   (tbl_attr),
      .walk_level_i (level),
      .xlat_flt_i   (xlat),
      .merged_attr_o(merged),
      .perm_r_o     (pr),
      .perm_w_o     (pw),
      .perm_x_o     (px),
      .fault_o      (flt),
      .fsr_o        (fsr)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         if (n_fail < 20)
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   initial begin
      @(negedge clk);
      // all-zero inputs: access flag clear, so an access fault at level 0 (R4)
      check({flt, fsr, pr, pw, px} == {1'b1, 10'h208, 3'b000}, "R4",
            {flt, fsr, pr, pw, px}, {1'b1, 10'h208, 3'b000});
      for (int k = 0; k < 4; k++)
      for (int u = 0; u < 2; u++)
      for (int s = 0; s < 32; s++)
      for (int t = 0; t < 32; t++)
      for (int l = 0; l < 4; l++)
      for (int x = 0; x < 2; x++) begin
         logic [12:0] lf, me;
         logic        xdeny;
         int          ty;
         logic [9:0]  efsr;
         logic [2:0]  eperm;
         string       tag;
         @(posedge clk);
         lf = 13'(((s * 37 + t * 5) & 13'h06CF));
         lf[4]  = s[0];
         lf[5]  = s[1];
         lf[8]  = s[2];
         lf[11] = s[3];
         lf[12] = s[4];
         acc_kind = 2'(k); acc_user = u[0]; leaf_attr = lf;
         tbl_attr = 5'(t); level = 2'(l); xlat = x[0];
         me = lf;
         me[11] = lf[11] | t[0];
         me[12] = lf[12] | t[1];
         me[5]  = lf[5]  | t[3];
         if (t[2]) me[4] = 1'b0;
         xdeny = me[12] | (!u[0] & me[11]);
         if (x[0])                 begin ty = 1; tag = "R3"; end
         else if (!me[8])          begin ty = 2; tag = "R4"; end
         else if (u[0] && !me[4])  begin ty = 3; tag = "R5"; end
         else if (k == 2 && xdeny) begin ty = 3; tag = "R6"; end
         else if (k == 1 && me[5]) begin ty = 3; tag = "R7"; end
         else                      begin ty = 0; tag = "R8"; end
         efsr  = (ty != 0) ? 10'(32'h200 | (ty << 2) | l) : 10'h000;
         eperm = (ty != 0) ? 3'b000 : {1'b1, !me[5], !xdeny};
         @(negedge clk);
         check(merged == me, (t[2] || t[4]) ? "R2" : "R1", 32'(merged), 32'(me));
         check({flt, fsr} == {ty != 0, efsr}, tag, {flt, fsr}, {ty != 0, efsr});
         check({pr, pw, px} == eperm, (ty != 0) ? "R9" : tag, 32'({pr, pw, px}),
               32'(eperm));
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule